// File: doc/BRIEF.md
# Dual LCD Contrast PWM

This block drives two LCD contrast pins with fixed-frequency pulse-width waveforms. A shared prescaler and period counter set one common period (1 kHz with the default parameters: a 1 MHz tick from a 50 MHz clock, 1000 ticks per period). Each channel has its own duty field: channel B takes a coarse 3-bit value and channel A a fine 5-bit value. Both fields come from a duty word.

A control word gates the pins. One mode bit gives pin B to a slowdown clock-control signal instead of the contrast waveform, and two enable bits gate the channels one by one. Decoding of the register bus lies outside the block. The block only receives the two register words as they stand.

Duty values are captured only when a period starts, so a duty write never cuts a pulse short or stretches it. The pins are registered outputs.

Top module: `lcd_bias_pwm`

## Requirements
- R1: While `rst` is high and after it is released, both pins are low until a period boundary has loaded a nonzero duty; the first boundary comes one full period after release.
- R2: The period is `PERIOD_TICKS` ticks, and each tick lasts `CLK_PER_TICK` clocks, so rising edges of a running pin are `PERIOD_TICKS*CLK_PER_TICK` clocks apart.
- R3: Channel B takes its duty from `duty_word[15:13]`, and its pin is high for floor(duty*PERIOD_TICKS/8) ticks of each period.
- R4: Channel A takes its duty from `duty_word[12:8]`, and its pin is high for floor(duty*PERIOD_TICKS/32) ticks of each period.
- R5: A duty value of zero keeps the channel's pin low for the whole period.
- R6: Pin A carries its waveform only when `ctl_word[14]`=0 and `ctl_word[8]`=1. Pin B carries its waveform only when `ctl_word[14]`=0 and `ctl_word[9]`=1. Otherwise a contrast pin is low.
- R7: When `ctl_word[14]`=1, pin B outputs `slow_in` delayed by one clock, and pin A is low.
- R8: A new duty value takes effect only at a period boundary. A value present in the last clock of a period governs the next period. A value that arrives one clock later waits a whole further period.
- R9: Changes to the enable and mode bits reach the pins one clock later, without waiting for a boundary.
- R10: Bits of `ctl_word` and `duty_word` outside the fields named in R3, R4 and R6 have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 16 | Control word: bit 14 is the slowdown mode, bit 9 enables B, bit 8 enables A |
| duty_word | input | 16 | Duty word: [15:13] sets the B duty, [12:8] sets the A duty |
| slow_in | input | 1 | Slowdown clock-control signal for pin B |
| lcd_a_o | output | 1 | Contrast pin A |
| lcd_b_o | output | 1 | Contrast pin B, or the slowdown output |

## Verification
The collision that matters is a duty-word change that lands in the same clock as a period boundary, where the counter wraps and the threshold reloads. The bench uses pin B's rising edge to find the phase of the period. It then changes the channel A duty exactly in the last clock of a period, and in a second run one clock after that. It counts high clocks over the following period and expects the new duty in the first run and the old duty in the second. A smaller collision, an enable drop in the middle of a pulse, is judged by pin B falling on the very next clock.

// File: rtl/lcd_bias_pkg.sv
package lcd_bias_pkg;

    localparam int NUM_CH     = 2;
    localparam int FIELD_W    = 5;
    localparam int MODE_BIT   = 14;
    localparam int EN_B_BIT   = 9;
    localparam int EN_A_BIT   = 8;
    localparam int DUTY_A_LSB = 8;
    localparam int DUTY_A_W   = 5;
    localparam int DUTY_B_LSB = 13;
    localparam int DUTY_B_W   = 3;

    typedef struct packed {
        logic slow_sel;
        logic en_b;
        logic en_a;
    } ctl_t;

    typedef enum logic [1:0] {
        SRC_LOW  = 2'd0,
        SRC_WAVE = 2'd1,
        SRC_SLOW = 2'd2
    } src_e;

    function automatic ctl_t ctl_decode(input logic [15:0] w);
        ctl_t c;
        c.slow_sel = w[MODE_BIT];
        c.en_b     = w[EN_B_BIT];
        c.en_a     = w[EN_A_BIT];
        return c;
    endfunction

    function automatic int duty_width(input int ch);
        return (ch == 0) ? DUTY_A_W : DUTY_B_W;
    endfunction

    function automatic logic [FIELD_W-1:0] duty_field(input logic [15:0] w, input int ch);
        logic [FIELD_W-1:0] f;
        if (ch == 0) f = w[DUTY_A_LSB +: DUTY_A_W];
        else         f = {2'b00, w[DUTY_B_LSB +: DUTY_B_W]};
        return f;
    endfunction

    function automatic src_e pick_src(input ctl_t c, input int ch);
        src_e s;
        if (ch == 0) s = (!c.slow_sel && c.en_a) ? SRC_WAVE : SRC_LOW;
        else if (c.slow_sel) s = SRC_SLOW;
        else s = c.en_b ? SRC_WAVE : SRC_LOW;
        return s;
    endfunction

endpackage

// File: rtl/lcd_bias_tick.sv
module lcd_bias_tick #(
    parameter int CLK_PER_TICK = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_PER_TICK - 1);

    logic [DIV_W-1:0] pre_q;

    assign tick = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/lcd_bias_phase.sv
module lcd_bias_phase #(
    parameter int PERIOD_TICKS = 1000,
    parameter int TW           = $clog2(PERIOD_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [TW-1:0] ph,
    output logic          bnd
);
    localparam logic [TW-1:0] PH_LAST = TW'(PERIOD_TICKS - 1);

    assign bnd = tick && (ph == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst)       ph <= '0;
        else if (bnd)  ph <= '0;
        else if (tick) ph <= ph + 1'b1;
    end
endmodule

// File: rtl/lcd_bias_chan.sv
module lcd_bias_chan #(
    parameter int PERIOD_TICKS = 1000,
    parameter int DW           = 5,
    parameter int TW           = $clog2(PERIOD_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bnd,
    input  logic [DW-1:0] duty,
    input  logic [TW-1:0] ph,
    output logic [TW-1:0] thr,
    output logic          wave
);
    localparam int PW = DW + TW;

    logic [PW-1:0] prod;
    logic [PW-1:0] scaled;

    assign prod   = PW'(duty) * PW'(PERIOD_TICKS);
    assign scaled = prod >> DW;
    assign wave   = (ph < thr);

    always_ff @(posedge clk) begin
        if (rst)      thr <= '0;
        else if (bnd) thr <= scaled[TW-1:0];
    end
endmodule

// File: rtl/lcd_bias_pwm.sv
module lcd_bias_pwm
    import lcd_bias_pkg::*;
#(
    parameter int CLK_PER_TICK = 50,
    parameter int PERIOD_TICKS = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] ctl_word,
    input  logic [15:0] duty_word,
    input  logic        slow_in,
    output logic        lcd_a_o,
    output logic        lcd_b_o
);
    localparam int TW = $clog2(PERIOD_TICKS + 1);

    logic                         tick;
    logic                         bnd;
    logic [TW-1:0]                ph_cnt;
    logic [NUM_CH-1:0][TW-1:0]    thr;
    logic [NUM_CH-1:0]            wave;
    logic [NUM_CH-1:0]            pin_w;
    ctl_t                         ctl;

    assign ctl = ctl_decode(ctl_word);

    lcd_bias_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    lcd_bias_phase #(.PERIOD_TICKS(PERIOD_TICKS), .TW(TW)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .ph   (ph_cnt),
        .bnd  (bnd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int DW = duty_width(g);

        logic [FIELD_W-1:0] field;
        logic               pin_q;
        src_e               src;

        assign field = duty_field(duty_word, g);
        assign src   = pick_src(ctl, g);

        lcd_bias_chan #(.PERIOD_TICKS(PERIOD_TICKS), .DW(DW), .TW(TW)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .bnd  (bnd),
            .duty (field[DW-1:0]),
            .ph   (ph_cnt),
            .thr  (thr[g]),
            .wave (wave[g])
        );

        always_ff @(posedge clk) begin
            if (rst) pin_q <= 1'b0;
            else begin
                case (src)
                    SRC_WAVE: pin_q <= wave[g];
                    SRC_SLOW: pin_q <= slow_in;
                    default:  pin_q <= 1'b0;
                endcase
            end
        end

        assign pin_w[g] = pin_q;
    end

    assign lcd_a_o = pin_w[0];
    assign lcd_b_o = pin_w[1];
endmodule

// File: rtl/lcd_bias_chk.sv
module lcd_bias_chk #(
    parameter int PERIOD_TICKS = 1000,
    parameter int TW           = $clog2(PERIOD_TICKS + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          mode,
    input logic          en_a,
    input logic          en_b,
    input logic          slow_in,
    input logic          pin_a,
    input logic          pin_b,
    input logic          bnd,
    input logic [TW-1:0] ph,
    input logic [TW-1:0] thr_a,
    input logic [TW-1:0] thr_b
);
    a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
        ph < TW'(PERIOD_TICKS));

    a_r7_slow_follow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode)) |-> (pin_b == $past(slow_in)));

    a_r6_a_gated: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(mode) || !$past(en_a))) |-> !pin_a);

    a_r6_b_gated: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mode) && !$past(en_b)) |-> !pin_b);

    a_r5_zero_a: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(thr_a) == '0)) |-> !pin_a);

    a_r5_zero_b: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mode) && ($past(thr_b) == '0)) |-> !pin_b);

    a_r8_hold_a: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bnd)) |-> $stable(thr_a));

    a_r8_hold_b: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bnd)) |-> $stable(thr_b));
endmodule

bind lcd_bias_pwm lcd_bias_chk #(.PERIOD_TICKS(PERIOD_TICKS), .TW(TW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (ctl_word[14]),
    .en_a    (ctl_word[8]),
    .en_b    (ctl_word[9]),
    .slow_in (slow_in),
    .pin_a   (lcd_a_o),
    .pin_b   (lcd_b_o),
    .bnd     (bnd),
    .ph      (ph_cnt),
    .thr_a   (thr[0]),
    .thr_b   (thr[1])
);

// File: tb/test_lcd_bias_pwm.sv
module test_lcd_bias_pwm;
    localparam int DIV   = 2;
    localparam int PER   = 64;
    localparam int CLKS  = DIV * PER;
    localparam int NVEC  = 9;

    localparam logic [15:0] V_CTL  [NVEC] = '{16'h0300, 16'h0300, 16'h0300, 16'h0300,
                                              16'h0100, 16'h0200, 16'h4300, 16'h0300, 16'hB3FF};
    localparam logic [15:0] V_DUTY [NVEC] = '{16'h9000, 16'h2100, 16'hFF00, 16'h0000,
                                              16'hFF00, 16'hFF00, 16'h9000, 16'h6A00, 16'h6AFF};
    localparam int V_EXP_A [NVEC] = '{64, 4, 124, 0, 124, 0, 0, 40, 40};
    localparam int V_EXP_B [NVEC] = '{64, 16, 112, 0, 0, 112, 0, 48, 48};
    localparam string V_REQ [NVEC] = '{"R3/R4", "R3/R4", "R3/R4", "R5", "R6",
                                       "R6", "R6/R7", "R3/R4", "R10"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctl_word = 16'h0300;
    logic [15:0] duty_word = 16'hFF00;
    logic        slow_in = 1'b0;
    logic        lcd_a_o;
    logic        lcd_b_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lcd_bias_pwm #(.CLK_PER_TICK(DIV), .PERIOD_TICKS(PER)) i_lcd_bias_pwm (
        .clk       (clk),
        .rst       (rst),
        .ctl_word  (ctl_word),
        .duty_word (duty_word),
        .slow_in   (slow_in),
        .lcd_a_o   (lcd_a_o),
        .lcd_b_o   (lcd_b_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic count_high(input int n, output int ca, output int cb);
        ca = 0;
        cb = 0;
        repeat (n) begin
            @(negedge clk);
            ca += int'(lcd_a_o);
            cb += int'(lcd_b_o);
        end
    endtask

    task automatic wait_rise_b();
        logic prev;
        prev = lcd_b_o;
        forever begin
            @(negedge clk);
            if (lcd_b_o && !prev) break;
            prev = lcd_b_o;
        end
    endtask

    initial begin
        int ca, cb;
        // R1: reset state
        repeat (5) @(negedge clk);
        check("R1 reset pin A", int'(lcd_a_o), 0);
        check("R1 reset pin B", int'(lcd_b_o), 0);
        rst = 1'b0;
        count_high(CLKS - 8, ca, cb);
        check("R1 first period A", ca, 0);
        check("R1 first period B", cb, 0);
        repeat (2 * CLKS) @(negedge clk);

        // table of steady-state patterns
        for (int i = 0; i < NVEC; i++) begin
            ctl_word  = V_CTL[i];
            duty_word = V_DUTY[i];
            slow_in   = 1'b0;
            repeat (2 * CLKS) @(negedge clk);
            count_high(CLKS, ca, cb);
            check({V_REQ[i], " pin A"}, ca, V_EXP_A[i]);
            check({V_REQ[i], " pin B"}, cb, V_EXP_B[i]);
        end

        // R2: period between rising edges of pin B
        ctl_word = 16'h0300;
        duty_word = 16'h4400;
        repeat (3 * CLKS) @(negedge clk);
        wait_rise_b();
        begin
            int gap;
            logic prev;
            gap = 0;
            prev = lcd_b_o;
            forever begin
                @(negedge clk);
                gap++;
                if (lcd_b_o && !prev) break;
                prev = lcd_b_o;
            end
            check("R2 period clocks", gap, CLKS);
        end

        // R8: change in last clock of a period applies to the next one
        wait_rise_b();
        repeat (CLKS - 2) @(negedge clk);
        duty_word = 16'h5400;
        @(negedge clk);
        count_high(CLKS, ca, cb);
        check("R8 on-boundary change A", ca, 80);
        check("R8 on-boundary B unchanged", cb, 32);

        // R8: one clock late waits a whole period
        duty_word = 16'h4400;
        repeat (3 * CLKS) @(negedge clk);
        wait_rise_b();
        repeat (CLKS - 1) @(negedge clk);
        duty_word = 16'h5400;
        count_high(CLKS, ca, cb);
        check("R8 late change A", ca, 16);
        count_high(CLKS, ca, cb);
        check("R8 late change next period A", ca, 80);

        // R9: enable drop in mid-pulse acts one clock later
        duty_word = 16'hFF00;
        repeat (3 * CLKS) @(negedge clk);
        wait_rise_b();
        @(negedge clk);
        check("R9 pin B high before drop", int'(lcd_b_o), 1);
        ctl_word = 16'h0100;
        @(negedge clk);
        check("R9 pin B low after drop", int'(lcd_b_o), 0);

        // R7: slowdown follow with a one-clock delay
        ctl_word = 16'h4300;
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            logic bit_v;
            bit_v = logic'((8'b1011_0010 >> k) & 1);
            slow_in = bit_v;
            @(negedge clk);
            check("R7 slow follow B", int'(lcd_b_o), int'(bit_v));
            check("R7 pin A low", int'(lcd_a_o), 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule